// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits on a store path that does not allocate into the cache. Each store carries an address, up to eight bytes of data and a byte-enable vector. Stores that fall in the same 64-byte line are gathered in one staging entry. They are not forwarded one at a time. A line whose 64 bytes have all been written leaves as a single full-line burst. A line that stays incomplete leaves after an idle timeout as a masked partial write that carries only the bytes it received.

A snoop input accepts the addresses of DMA writes. If a DMA write lands in a line that is still staged, the staged CPU data for that line is discarded. This prevents older processor data from reaching memory after the DMA data and overwriting it. The buffer holds a small fixed number of entries. If a store needs a new entry and none is free, the input stalls for one cycle while the entry idle for the longest time is pushed out.

Top module: `wcb_top`

## Requirements
- R1: A store whose address bits [ADDR_W-1:6] match an open entry merges into that entry. When `st_be[b]` is set, store byte b (`st_data[8b+:8]`) goes to line byte 8*`st_addr[5:3]`+b. That is `out_data[8k+:8]` with mask bit k for line byte k. `st_addr[2:0]` is ignored, and at most one entry is ever open per line.
- R2: In the cycle after the clock edge that writes the last missing byte of an entry, the entry is presented with `out_valid`=1, `out_full`=1 and `out_mask` all ones. It is then removed.
- R3: An entry that receives no store for TIMEOUT (16) edges after its last write is presented with `out_valid`=1 and `out_full`=0. It appears in the cycle after the 16th such edge, and `out_mask` holds exactly the bytes written.
- R4: A store to a byte that is already valid replaces that byte, so the last write wins.
- R5: A store that merges into an entry restarts that entry's timeout.
- R6: Up to NUM_ENT (4) lines can be open at once. Suppose a store to a new line arrives while all entries are open and no other flush or DMA cancel is happening. In that cycle `st_ready` is 0 and the entry written least recently is flushed. The store is accepted in the next cycle.
- R7: If `dma_valid` is 1 and `dma_addr` falls in an open line, that entry is discarded at the edge and is never flushed. The output in that same cycle does not show that line, even if the entry was due to flush. A store to the same line in the same cycle is dropped.
- R8: At most one entry is presented per cycle, and each flushed line is presented once. Full entries take precedence over timed-out ones, and the lower index wins among equals.
- R9: While reset is held and in the cycle after it is released, `out_valid` is 0 and `st_ready` is 1.
- R10: After a line has been flushed, a new store to it opens a fresh entry whose mask holds only the new bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle (0 = stall) |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | 64 | Store data, byte b at bits 8b+7:8b |
| st_be | input | 8 | Store byte enables |
| dma_valid | input | 1 | DMA write snoop present |
| dma_addr | input | ADDR_W | DMA write address |
| out_valid | output | 1 | Line write to memory presented this cycle |
| out_addr | output | ADDR_W | Line-aligned address of the write |
| out_data | output | 512 | Line data, byte k at bits 8k+7:8k |
| out_mask | output | 64 | Bytes of the line that are written |
| out_full | output | 1 | All 64 bytes valid (full burst) |

## Verification
A run of ten stores walks one line with mixed enables. The run includes a partial word finished by a second store at an unaligned address and an overwrite of an earlier byte. It shows that merging, byte placement and last-write-wins are correct, and that the full burst appears exactly on the completing store and not before it. Single partial stores checked at edge 15 and edge 16 pin the timeout boundary, and a re-store at edge 10 separates a restarted timer from a free-running one. Five distinct lines force the stall and show which entry is evicted. A full line and a timed-out line that become due in the same cycle show the priority order. DMA snoops are applied to an open partial line, together with a same-cycle store, and to a full line in its flush cycle. These show that the cancellation takes effect at once and that nothing leaks out later.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  localparam int unsigned LINE_BYTES = 64;
  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned SLOTS      = LINE_BYTES / WORD_BYTES;
  localparam int unsigned OFS_W      = $clog2(LINE_BYTES);
  localparam int unsigned SLOT_W     = $clog2(SLOTS);
  localparam int unsigned BYTE_OFS_W = $clog2(WORD_BYTES);

  typedef logic [LINE_BYTES-1:0]      bytemask_t;
  typedef logic [LINE_BYTES*8-1:0]    linedata_t;
  typedef logic [WORD_BYTES-1:0]      wordbe_t;
  typedef logic [WORD_BYTES*8-1:0]    worddata_t;

  // line mask covering the enabled bytes of one word slot
  function automatic bytemask_t place_mask(logic [SLOT_W-1:0] slot, wordbe_t be);
    bytemask_t m;
    m = '0;
    m[slot*WORD_BYTES +: WORD_BYTES] = be;
    return m;
  endfunction

  // word data shifted to its slot inside a line
  function automatic linedata_t place_data(logic [SLOT_W-1:0] slot, worddata_t d);
    linedata_t r;
    r = '0;
    r[slot*WORD_BYTES*8 +: WORD_BYTES*8] = d;
    return r;
  endfunction

  // byte-wise select: masked bytes from nw, others kept from old
  function automatic linedata_t merge_bytes(linedata_t old, linedata_t nw, bytemask_t m);
    linedata_t r;
    for (int b = 0; b < LINE_BYTES; b++)
      r[b*8 +: 8] = m[b] ? nw[b*8 +: 8] : old[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/wcb_entry.sv
module wcb_entry
  import wcb_pkg::*;
#(
  parameter int unsigned TAG_W   = 26,
  parameter int unsigned TIMEOUT = 16,
  parameter int unsigned AGE_W   = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_new,
  input  logic [TAG_W-1:0] wr_tag,
  input  bytemask_t        wr_mask,
  input  linedata_t        wr_data,
  input  logic             drop,
  output logic             vld,
  output logic [TAG_W-1:0] tag,
  output linedata_t        data,
  output bytemask_t        mask,
  output logic [AGE_W-1:0] age,
  output logic             full,
  output logic             expired
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      tag  <= '0;
      data <= '0;
      mask <= '0;
      age  <= '0;
    end else if (drop) begin
      vld  <= 1'b0;
      mask <= '0;
      age  <= '0;
    end else if (wr_en) begin
      vld  <= 1'b1;
      if (wr_new) tag <= wr_tag;
      mask <= (wr_new ? '0 : mask) | wr_mask;
      data <= merge_bytes(data, wr_data, wr_mask);
      age  <= '0;
    end else if (vld && age != AGE_W'(TIMEOUT)) begin
      age <= age + 1'b1;
    end
  end

  assign full    = vld && (&mask);
  assign expired = vld && (age == AGE_W'(TIMEOUT));
endmodule

// File: rtl/wcb_pick.sv
module wcb_pick #(
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned AGE_W   = 5,
  parameter int unsigned IDX_W   = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0]            elig,
  input  logic [NUM_ENT-1:0]            full_v,
  input  logic [NUM_ENT-1:0]            exp_v,
  input  logic [NUM_ENT-1:0]            hold_v,
  input  logic [NUM_ENT-1:0][AGE_W-1:0] ages,
  input  logic                          evict_req,
  output logic                          sel_v,
  output logic [IDX_W-1:0]              sel_idx
);
  logic [NUM_ENT-1:0] full_c, exp_c;
  logic [AGE_W-1:0]   best_age;
  logic               seen;

  assign full_c = elig & full_v;
  assign exp_c  = elig & exp_v & ~hold_v;

  always_comb begin
    sel_v    = 1'b0;
    sel_idx  = '0;
    best_age = '0;
    seen     = 1'b0;
    if (|full_c) begin
      sel_v = 1'b1;
      for (int i = NUM_ENT - 1; i >= 0; i--)
        if (full_c[i]) sel_idx = IDX_W'(i);
    end else if (|exp_c) begin
      sel_v = 1'b1;
      for (int i = NUM_ENT - 1; i >= 0; i--)
        if (exp_c[i]) sel_idx = IDX_W'(i);
    end else if (evict_req) begin
      for (int i = 0; i < NUM_ENT; i++)
        if (elig[i] && (!seen || ages[i] > best_age)) begin
          seen     = 1'b1;
          best_age = ages[i];
          sel_idx  = IDX_W'(i);
        end
      sel_v = seen;
    end
  end
endmodule

// File: rtl/wcb_top.sv
module wcb_top
  import wcb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [63:0]       st_data,
  input  logic [7:0]        st_be,
  input  logic              dma_valid,
  input  logic [ADDR_W-1:0] dma_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [511:0]      out_data,
  output logic [63:0]       out_mask,
  output logic              out_full
);
  localparam int unsigned TAG_W = ADDR_W - OFS_W;
  localparam int unsigned AGE_W = $clog2(TIMEOUT + 1);
  localparam int unsigned IDX_W = $clog2(NUM_ENT);

  logic [TAG_W-1:0]  st_tag, dma_tag;
  logic [SLOT_W-1:0] st_slot;
  bytemask_t         st_mask;
  linedata_t         st_line;

  logic [NUM_ENT-1:0]            ent_vld, ent_full, ent_exp, ent_wr, ent_drop;
  logic [NUM_ENT-1:0][TAG_W-1:0] ent_tag;
  logic [NUM_ENT-1:0][AGE_W-1:0] ent_age;
  linedata_t                     ent_data [NUM_ENT];
  bytemask_t                     ent_mask [NUM_ENT];

  // named internal events for the checker
  logic [NUM_ENT-1:0] hit_vec, kill_vec;
  logic               hit_any, free_any, evict_req, conflict, st_take, st_vs_dma;
  logic [IDX_W-1:0]   hit_idx, free_idx, flush_idx;
  logic               flush_v;
  logic               unused_lo;

  assign st_tag    = st_addr[ADDR_W-1:OFS_W];
  assign dma_tag   = dma_addr[ADDR_W-1:OFS_W];
  assign st_slot   = st_addr[OFS_W-1:BYTE_OFS_W];
  assign st_mask   = place_mask(st_slot, st_be);
  assign st_line   = place_data(st_slot, st_data);
  assign unused_lo = ^{st_addr[BYTE_OFS_W-1:0], dma_addr[OFS_W-1:0]};

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      hit_vec[i]  = ent_vld[i] && (ent_tag[i] == st_tag);
      kill_vec[i] = dma_valid && ent_vld[i] && (ent_tag[i] == dma_tag);
      if (hit_vec[i])  hit_idx  = IDX_W'(i);
      if (!ent_vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign hit_any   = |hit_vec;
  assign free_any  = ~&ent_vld;
  assign evict_req = st_valid && !hit_any && !free_any;

  wcb_pick #(.NUM_ENT(NUM_ENT), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick (
    .elig     (ent_vld & ~kill_vec),
    .full_v   (ent_full),
    .exp_v    (ent_exp),
    .hold_v   (st_valid ? hit_vec : '0),
    .ages     (ent_age),
    .evict_req(evict_req),
    .sel_v    (flush_v),
    .sel_idx  (flush_idx)
  );

  assign conflict  = hit_any && flush_v && (flush_idx == hit_idx);
  assign st_ready  = !(st_valid && (evict_req || conflict));
  assign st_take   = st_valid && st_ready;
  assign st_vs_dma = dma_valid && (dma_tag == st_tag);

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      ent_wr[i]   = st_take && !st_vs_dma &&
                    (hit_any ? hit_vec[i] : (free_idx == IDX_W'(i)));
      ent_drop[i] = kill_vec[i] || (flush_v && flush_idx == IDX_W'(i));
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    wcb_entry #(.TAG_W(TAG_W), .TIMEOUT(TIMEOUT), .AGE_W(AGE_W)) u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ent_wr[g]),
      .wr_new (!hit_any),
      .wr_tag (st_tag),
      .wr_mask(st_mask),
      .wr_data(st_line),
      .drop   (ent_drop[g]),
      .vld    (ent_vld[g]),
      .tag    (ent_tag[g]),
      .data   (ent_data[g]),
      .mask   (ent_mask[g]),
      .age    (ent_age[g]),
      .full   (ent_full[g]),
      .expired(ent_exp[g])
    );
  end

  assign out_valid = flush_v;
  assign out_addr  = {ent_tag[flush_idx], {OFS_W{1'b0}}};
  assign out_data  = ent_data[flush_idx];
  assign out_mask  = ent_mask[flush_idx];
  assign out_full  = ent_full[flush_idx];
endmodule

// File: rtl/wcb_check.sv
module wcb_check
  import wcb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_ENT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_valid,
  input logic               st_ready,
  input logic               dma_valid,
  input logic [ADDR_W-1:0]  dma_addr,
  input logic               out_valid,
  input logic [ADDR_W-1:0]  out_addr,
  input logic [63:0]        out_mask,
  input logic               out_full,
  input logic [NUM_ENT-1:0] kill_vec
);
  logic unused_dma_lo;
  assign unused_dma_lo = ^dma_addr[OFS_W-1:0];

  // R1: one entry per line, so a snoop never matches two entries
  p_unique_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kill_vec));

  // R2: a full burst carries every byte
  p_full_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_full |-> &out_mask);

  // R3: a flush never goes out empty
  p_nonempty_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> |out_mask);

  // R6: a stall is paired with an eviction or a cancel
  p_stall_evicts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |-> out_valid || dma_valid);

  // R7: a snooped line is never written out in the snoop cycle
  p_dma_blocks_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && out_valid |-> out_addr[ADDR_W-1:OFS_W] != dma_addr[ADDR_W-1:OFS_W]);

  // R8: a line is presented once, not in two consecutive cycles
  p_single_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !(out_valid && out_addr == $past(out_addr)));
endmodule

bind wcb_top wcb_check #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .st_valid (st_valid),
  .st_ready (st_ready),
  .dma_valid(dma_valid),
  .dma_addr (dma_addr),
  .out_valid(out_valid),
  .out_addr (out_addr),
  .out_mask (out_mask),
  .out_full (out_full),
  .kill_vec (kill_vec)
);

// File: tb/sim_wcb_top.sv
`timescale 1ns/1ps
module sim_wcb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [31:0]  st_addr = '0;
  logic [63:0]  st_data = '0;
  logic [7:0]   st_be = '0;
  logic         dma_valid = 1'b0;
  logic [31:0]  dma_addr = '0;
  logic         out_valid;
  logic [31:0]  out_addr;
  logic [511:0] out_data;
  logic [63:0]  out_mask;
  logic         out_full;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  wcb_top u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .dma_valid(dma_valid), .dma_addr(dma_addr), .out_valid(out_valid),
    .out_addr(out_addr), .out_data(out_data), .out_mask(out_mask), .out_full(out_full)
  );

  // {address, byte enables, data, full flush expected after this store}
  localparam logic [104:0] VEC [10] = '{
    {32'h0000_1000, 8'hFF, 64'h0706_0504_0302_0100, 1'b0},
    {32'h0000_1008, 8'h0F, 64'h0000_0000_1312_1110, 1'b0},
    {32'h0000_100C, 8'hF0, 64'h1716_1514_0000_0000, 1'b0},
    {32'h0000_1003, 8'h01, 64'h0000_0000_0000_00EE, 1'b0},
    {32'h0000_1010, 8'hFF, 64'h2726_2524_2322_2120, 1'b0},
    {32'h0000_1018, 8'hFF, 64'h3736_3534_3332_3130, 1'b0},
    {32'h0000_1020, 8'hFF, 64'h4746_4544_4342_4140, 1'b0},
    {32'h0000_1028, 8'hFF, 64'h5756_5554_5352_5150, 1'b0},
    {32'h0000_1030, 8'hFF, 64'h6766_6564_6362_6160, 1'b0},
    {32'h0000_1038, 8'hFF, 64'h7776_7574_7372_7170, 1'b1}
  };

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic put(input logic [31:0] a, input logic [7:0] be, input logic [63:0] d);
    st_valid = 1'b1; st_addr = a; st_be = be; st_data = d;
    #1;
    while (!st_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    chk("R9 out_valid in reset", 512'(out_valid), 512'd0);
    chk("R9 st_ready in reset", 512'(st_ready), 512'd1);
    rst_n = 1'b1;
    tick(1);
    chk("R9 out_valid after reset", 512'(out_valid), 512'd0);
  endtask

  task automatic quiet_window(input string req, input int n);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (out_valid) seen++;
    end
    chk(req, 512'(seen), 512'd0);
  endtask

  logic [7:0]   mdl [64];
  logic [511:0] exp_line;

  initial begin
    do_reset();

    // R1 R2 R4: table walk on one line
    for (int b = 0; b < 64; b++) mdl[b] = 8'h00;
    for (int v = 0; v < 10; v++) begin
      logic [31:0] a;
      logic [7:0]  be;
      logic [63:0] d;
      {a, be, d} = VEC[v][104:1];
      for (int b = 0; b < 8; b++)
        if (be[b]) mdl[a[5:3]*8 + b] = d[8*b +: 8];
      put(a, be, d);
      chk("R2 full flush timing", 512'({out_valid, out_full}), 512'({2{VEC[v][0]}}));
    end
    for (int b = 0; b < 64; b++) exp_line[8*b +: 8] = mdl[b];
    chk("R1 R4 merged line data", out_data, exp_line);
    chk("R2 full mask", 512'(out_mask), 512'({64{1'b1}}));
    chk("R1 flush address", 512'(out_addr), 512'h1000);
    tick(1);
    chk("R8 flushed once", 512'(out_valid), 512'd0);

    // R10: fresh entry after flush, checked via timeout
    put(32'h1000, 8'h01, 64'hAB);
    tick(16);
    chk("R10 fresh mask", 512'(out_mask), 512'd1);
    chk("R10 fresh byte", 512'(out_data[7:0]), 512'hAB);
    tick(1);

    // R3: timeout boundary
    do_reset();
    put(32'h2058, 8'h3C, 64'h1122_3344_5566_7788);
    tick(15);
    chk("R3 not yet expired", 512'(out_valid), 512'd0);
    tick(1);
    chk("R3 expired flush", 512'({out_valid, out_full}), 512'b10);
    chk("R3 partial mask", 512'(out_mask), 512'(64'h3C << 24));
    chk("R3 partial data", 512'(out_data[26*8 +: 32]), 512'h3344_5566);
    chk("R3 address", 512'(out_addr), 512'h2040);
    tick(1);
    chk("R3 single flush", 512'(out_valid), 512'd0);

    // R5: merge restarts the timer
    do_reset();
    put(32'h3080, 8'hFF, 64'h1);
    tick(10);
    put(32'h3088, 8'hFF, 64'h2);
    tick(15);
    chk("R5 timer restarted", 512'(out_valid), 512'd0);
    tick(1);
    chk("R5 flush after restart", 512'({out_valid, out_mask}), 512'({1'b1, 64'hFFFF}));

    // R6: eviction of least recently written line
    do_reset();
    for (int i = 0; i < 4; i++) put(32'h4000 + 32'(i) * 32'h40, 8'h01, 64'h5);
    st_valid = 1'b1; st_addr = 32'h5000; st_be = 8'h01; st_data = 64'h9;
    #1;
    chk("R6 stall on full buffer", 512'(st_ready), 512'd0);
    chk("R6 evicts oldest", 512'({out_valid, out_addr}), 512'({1'b1, 32'h4000}));
    @(negedge clk); #1;
    chk("R6 accepted next cycle", 512'(st_ready), 512'd1);
    @(posedge clk); @(negedge clk);
    st_valid = 1'b0;
    #1;

    // R8: full beats timed-out in the same cycle
    do_reset();
    put(32'h6000, 8'h01, 64'h77);
    tick(8);
    for (int i = 0; i < 8; i++) put(32'h6040 + 32'(i) * 8, 8'hFF, 64'h0);
    chk("R8 full first", 512'({out_valid, out_full, out_addr}), 512'({2'b11, 32'h6040}));
    tick(1);
    chk("R8 timed-out second", 512'({out_valid, out_full, out_addr}), 512'({2'b10, 32'h6000}));
    tick(1);
    chk("R8 then idle", 512'(out_valid), 512'd0);

    // R7: DMA cancels a partial line
    do_reset();
    put(32'h7000, 8'hFF, 64'h1);
    put(32'h7008, 8'hFF, 64'h2);
    dma_valid = 1'b1; dma_addr = 32'h7014;
    tick(1);
    dma_valid = 1'b0;
    quiet_window("R7 cancelled partial never flushed", 20);

    // R7: store and DMA to the same line in one cycle
    st_valid = 1'b1; st_addr = 32'h7400; st_be = 8'h0F; st_data = 64'h3;
    dma_valid = 1'b1; dma_addr = 32'h7420;
    tick(1);
    st_valid = 1'b0; dma_valid = 1'b0;
    quiet_window("R7 same-cycle store dropped", 20);

    // R7: DMA in the flush cycle of a full line
    for (int i = 0; i < 8; i++) put(32'h7800 + 32'(i) * 8, 8'hFF, 64'h4);
    chk("R7 full line due", 512'(out_valid), 512'd1);
    dma_valid = 1'b1; dma_addr = 32'h7830;
    #1;
    chk("R7 flush suppressed same cycle", 512'(out_valid), 512'd0);
    tick(1);
    dma_valid = 1'b0;
    quiet_window("R7 full line cancelled", 20);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule